// File: doc/BRIEF.md
# Warp Lane Shuffle Crossbar

This block exchanges data words among the lanes of a warp in one registered step. Each lane presents a data word. The unit gives each lane back a word taken from a source lane. The rule for choosing that source lane is set by a two-bit mode: shift up, shift down, XOR butterfly, or direct index. All lanes share one offset/index operand and one packed control operand. The control operand holds a clamp value and a segment mask, and together they split the warp into sub-segments and set an upper bound for each.

If a lane's computed source falls outside its allowed range, that lane keeps its own word and its predicate bit is cleared. If the source is in range, the lane receives the source lane's word and its predicate bit is set. A per-lane active mask is accepted. When a lane's source is inactive, the word that lane receives is undefined. Inputs are captured on `in_valid`, and the results appear on the next cycle with `out_valid`.

Top module: `lane_shuffle_xbar`

## Requirements
- R1: After a synchronous reset, `out_valid`, `out_pred` and `out_data` are all zero.
- R2: `out_valid` is high exactly one cycle after `in_valid`. `out_data` and `out_pred` change only in the cycle after an `in_valid` and hold their values otherwise.
- R3: With mode 0 (up), lane L takes the word of lane L minus the offset, when that source index is at or above the lane's bound.
- R4: With mode 1 (down), lane L takes the word of lane L plus the offset, when that sum is at or below the lane's bound.
- R5: With mode 2 (butterfly), lane L takes the word of lane L XOR offset, when that index is at or below the lane's bound.
- R6: With mode 3 (index), lane L takes the word of lane (L AND mask) OR (offset AND NOT mask), when that index is at or below the lane's bound.
- R7: The bound of lane L is (L AND mask) OR (clamp AND NOT mask). A lane whose source is out of range gets its own word and `out_pred` bit 0. A lane whose source is in range gets `out_pred` bit 1.
- R8: Only `offset[4:0]` is used. An offset above 31 acts like its low five bits and can still give a valid, predicated transfer.
- R9: The clamp is `ctrl[4:0]` and the segment mask is `ctrl[12:8]`. All other `ctrl` bits have no effect.
- R10: In up mode a negative difference (offset greater than the lane index) is out of range, whatever the bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Capture strobe for the operands |
| mode | input | 2 | 0 up, 1 down, 2 butterfly, 3 index |
| lane_data | input | LANES*DW | Lane words, lane i at bits [i*DW +: DW] |
| active | input | LANES | Per-lane active mask |
| offset | input | 32 | Shared offset or index operand |
| ctrl | input | 32 | Packed clamp [4:0] and segment mask [12:8] |
| out_valid | output | 1 | Results valid |
| out_data | output | LANES*DW | Shuffled words, same layout as input |
| out_pred | output | LANES | Per-lane in-range predicate |

## Verification
The bench uses the default build of 32 lanes with 32-bit words. This gives the full five-bit lane index, so the up shift can run below lane 0, the down shift can run past lane 31, and the segment masks can split the warp into groups of 4 or 8 lanes. Each lane word holds its own lane number in several byte fields together with a per-vector seed. A wrong source lane therefore gives a different word, and so does a stale capture. Lanes whose source is inactive are left out of the comparison.

// File: rtl/lane_shfl_pkg.sv
package lane_shfl_pkg;
  typedef enum logic [1:0] {
    SHF_UP   = 2'd0,
    SHF_DOWN = 2'd1,
    SHF_XOR  = 2'd2,
    SHF_IDX  = 2'd3
  } shf_mode_e;

  localparam int unsigned CLAMP_LSB = 0;
  localparam int unsigned MASK_LSB  = 8;
endpackage

// File: rtl/shfl_src_sel.sv
module shfl_src_sel
  import lane_shfl_pkg::*;
#(
  parameter int unsigned LW      = 5,
  parameter int unsigned LANE_ID = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  shf_mode_e         mode,
  input  logic [LW-1:0]     bval,
  input  logic [LW-1:0]     clamp,
  input  logic [LW-1:0]     mask,
  output logic [LW-1:0]     src,
  output logic              ok
);
  localparam logic [LW-1:0] LID = LW'(LANE_ID);

  logic [LW-1:0] seg_base, upper, j;
  logic [LW:0]   diff, sum;

  assign seg_base = LID & mask;
  assign upper    = seg_base | (clamp & ~mask);
  assign diff     = {1'b0, LID} - {1'b0, bval};
  assign sum      = {1'b0, LID} + {1'b0, bval};

  always_comb begin
    j  = LID;
    ok = 1'b0;
    unique case (mode)
      SHF_UP: begin
        j  = diff[LW-1:0];
        ok = !diff[LW] && (diff[LW-1:0] >= upper);
      end
      SHF_DOWN: begin
        j  = sum[LW-1:0];
        ok = !sum[LW] && (sum[LW-1:0] <= upper);
      end
      SHF_XOR: begin
        j  = LID ^ bval;
        ok = (j <= upper);
      end
      SHF_IDX: begin
        j  = seg_base | (bval & ~mask);
        ok = (j <= upper);
      end
      default: begin
        j  = LID;
        ok = 1'b0;
      end
    endcase
  end

  assign src = ok ? j : LID;

  // R7: a source that is accepted outside up mode never passes the segment bound
  assert_src_bounded_R7: assert property (@(posedge clk) disable iff (rst)
    (ok && mode != SHF_UP) |-> (src <= upper));
endmodule

// File: rtl/shfl_word_mux.sv
module shfl_word_mux #(
  parameter int unsigned LANES = 32,
  parameter int unsigned DW    = 32,
  localparam int unsigned LW   = $clog2(LANES)
) (
  input  logic [LANES*DW-1:0] words,
  input  logic [LANES-1:0]    active,
  input  logic [LW-1:0]       src,
  input  logic [DW-1:0]       own,
  output logic [DW-1:0]       picked
);
  always_comb begin
    picked = own;
    if (active[src]) picked = words[src*DW +: DW];
  end
endmodule

// File: rtl/lane_shuffle_xbar.sv
module lane_shuffle_xbar
  import lane_shfl_pkg::*;
#(
  parameter int unsigned LANES = 32,
  parameter int unsigned DW    = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [1:0]          mode,
  input  logic [LANES*DW-1:0] lane_data,
  input  logic [LANES-1:0]    active,
  input  logic [31:0]         offset,
  input  logic [31:0]         ctrl,
  output logic                out_valid,
  output logic [LANES*DW-1:0] out_data,
  output logic [LANES-1:0]    out_pred
);
  localparam int unsigned LW = $clog2(LANES);

  shf_mode_e     mode_e;
  logic [LW-1:0] bval, clamp, mask;
  logic [LANES*DW-1:0] nxt_data;
  logic [LANES-1:0]    nxt_pred;

  assign mode_e = shf_mode_e'(mode);
  assign bval   = offset[LW-1:0];
  assign clamp  = ctrl[CLAMP_LSB +: LW];
  assign mask   = ctrl[MASK_LSB +: LW];

  wire unused_bits = ^{offset[31:LW], ctrl[31:MASK_LSB+LW], ctrl[MASK_LSB-1:CLAMP_LSB+LW]};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LW-1:0] src;
    logic          ok;
    logic [DW-1:0] own;

    assign own = lane_data[i*DW +: DW];

    shfl_src_sel #(.LW(LW), .LANE_ID(i)) u_sel (
      .clk(clk), .rst(rst), .mode(mode_e), .bval(bval),
      .clamp(clamp), .mask(mask), .src(src), .ok(ok)
    );

    shfl_word_mux #(.LANES(LANES), .DW(DW)) u_mux (
      .words(lane_data), .active(active), .src(src),
      .own(own), .picked(nxt_data[i*DW +: DW])
    );

    assign nxt_pred[i] = ok;

    // R7: a lane without an in-range source carries its own word
    assert_own_fallback_R7: assert property (@(posedge clk) disable iff (rst)
      !nxt_pred[i] |-> (nxt_data[i*DW +: DW] == own));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_pred  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= nxt_data;
        out_pred <= nxt_pred;
      end
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_pred) && $stable(out_data)));
endmodule

// File: tb/lane_shuffle_xbar_tb.sv
module lane_shuffle_xbar_tb;
  localparam int LANES = 32;
  localparam int DW    = 32;

  typedef struct packed {
    logic [1:0]  mode;
    logic [31:0] off;
    logic [31:0] ctrl;
    logic [7:0]  seed;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 32'h1,  32'h0,         8'h11}, // R3 scan step
    '{2'd0, 32'h4,  32'h1f,        8'h12}, // R7 up with high bound
    '{2'd0, 32'h3,  32'h0,         8'h13}, // R10 negative difference
    '{2'd1, 32'h1,  32'h1f,        8'h14}, // R4
    '{2'd1, 32'h8,  32'h0f,        8'h15}, // R7 clamp 15
    '{2'd2, 32'h10, 32'h1f,        8'h16}, // R5
    '{2'd2, 32'h1,  32'h0818,      8'h17}, // R9 mask 8, clamp 0x18
    '{2'd3, 32'h3,  32'h1c1f,      8'h18}, // R6 segments of 4
    '{2'd3, 32'h25, 32'h1f,        8'h19}, // R8 broadcast lane 5
    '{2'd1, 32'h21, 32'hffff_e01f, 8'h1a}, // R8 R9 ignored bits
    '{2'd3, 32'h7,  32'h1803,      8'h1b}  // R7 index past bound
  };

  logic clk = 0, rst = 1, in_valid = 0;
  logic [1:0] mode = 0;
  logic [LANES*DW-1:0] lane_data = '0;
  logic [LANES-1:0] active = '1;
  logic [31:0] offset = 0, ctrl = 0;
  logic out_valid;
  logic [LANES*DW-1:0] out_data;
  logic [LANES-1:0] out_pred;

  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  lane_shuffle_xbar #(.LANES(LANES), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
    .lane_data(lane_data), .active(active), .offset(offset), .ctrl(ctrl),
    .out_valid(out_valid), .out_data(out_data), .out_pred(out_pred)
  );

  function automatic logic [DW-1:0] word_of(int l, logic [7:0] seed);
    return {seed, 8'(l * 7), ~8'(l), 8'(l)};
  endfunction

  // reference source per lane from the mode rules
  function automatic int ref_src(int l, logic [1:0] m, logic [31:0] off,
                                 logic [31:0] c, output bit ok);
    int b, cl, mk, base, up, j;
    b = int'(off[4:0]); cl = int'(c[4:0]); mk = int'(c[12:8]);
    base = l & mk; up = base | (cl & ~mk & 31);
    case (m)
      2'd0: begin j = l - b; ok = (j >= 0) && (j >= up); end
      2'd1: begin j = l + b; ok = (j <= 31) && (j <= up); end
      2'd2: begin j = l ^ b; ok = (j <= up); end
      default: begin j = base | (b & ~mk & 31); ok = (j <= up); end
    endcase
    if (!ok) j = l;
    return j;
  endfunction

  task automatic apply(vec_t v, logic [LANES-1:0] act);
    @(negedge clk);
    for (int l = 0; l < LANES; l++) lane_data[l*DW +: DW] = word_of(l, v.seed);
    mode = v.mode; offset = v.off; ctrl = v.ctrl; active = act; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic check_vec(vec_t v, logic [LANES-1:0] act, string req);
    int bad_lane;
    logic [DW-1:0] got, exp;
    logic [LANES-1:0] pexp;
    bad_lane = -1; got = '0; exp = '0;
    for (int l = 0; l < LANES; l++) begin
      bit ok; int s;
      s = ref_src(l, v.mode, v.off, v.ctrl, ok);
      pexp[l] = ok;
      if (act[s] && bad_lane < 0 && out_data[l*DW +: DW] !== word_of(s, v.seed)) begin
        bad_lane = l; got = out_data[l*DW +: DW]; exp = word_of(s, v.seed);
      end
    end
    tests++;
    if (bad_lane >= 0) begin
      fails++;
      $display("FAIL %s data lane %0d: got %h expected %h", req, bad_lane, got, exp);
    end
    tests++;
    if (out_pred !== pexp || out_valid !== 1'b1) begin
      fails++;
      $display("FAIL %s pred/valid: got %h/%b expected %h/1", req, out_pred, out_valid, pexp);
    end
  endtask

  initial begin : watchdog
    #200000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    vec_t hv;
    logic [LANES*DW-1:0] keep_d;
    logic [LANES-1:0] keep_p, act5;
    repeat (3) @(negedge clk);
    tests++; // R1 reset state
    if (out_valid !== 0 || out_pred !== '0 || out_data !== '0) begin
      fails++;
      $display("FAIL R1 reset: got %b/%h expected 0/0", out_valid, out_pred);
    end
    rst = 0;

    for (int k = 0; k < NV; k++) begin
      apply(VECS[k], '1);
      check_vec(VECS[k], '1, $sformatf("R3-R10 vec%0d", k));
    end

    // R2: outputs hold and valid drops while idle, even with inputs changing
    keep_d = out_data; keep_p = out_pred;
    @(negedge clk);
    mode = 2'd1; offset = 32'h5; lane_data = '1;
    @(negedge clk);
    tests++;
    if (out_valid !== 0 || out_data !== keep_d || out_pred !== keep_p) begin
      fails++;
      $display("FAIL R2 hold: got valid %b pred %h expected 0 %h", out_valid, out_pred, keep_p);
    end

    // R3 with an inactive lane: lane 6 sources lane 5 and is skipped
    hv = '{2'd0, 32'h1, 32'h0, 8'h2c};
    act5 = '1; act5[5] = 1'b0;
    apply(hv, act5);
    check_vec(hv, act5, "R3 inactive");

    // R10: offset 31 in up mode, only lane 31 reaches lane 0
    hv = '{2'd0, 32'h1f, 32'h0, 8'h3d};
    apply(hv, '1);
    check_vec(hv, '1, "R10 max offset");

    // R1 again: reset mid-stream clears outputs
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    tests++;
    if (out_valid !== 0 || out_pred !== '0 || out_data !== '0) begin
      fails++;
      $display("FAIL R1 re-reset: got %b/%h expected 0/0", out_valid, out_pred);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule